// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a supervisory timer for a processor subsystem. Software programs a reload value, starts the counter, and must then service the timer at regular intervals by writing a clear register. If software stops servicing it, the first expiry raises a maskable interrupt so that a handler can try to recover. If the interrupt is still unserviced when the counter expires again, the block raises a system reset request, provided reset generation is enabled.

Software reaches the block through a plain single-cycle register port made of a write strobe, a word address, write data and combinational read data. A lock register guards the configuration and reload registers against stray writes from runaway code. Writing the unlock key opens it, and any other value closes it. A stall option freezes the counter while a debug halt input is high, so that a breakpoint does not cause a spurious reset.

Top module: `wdog_timer`

## Requirements
- R1: After reset the reload and value registers read 0xFFFFFFFF, the control, raw-status and lock registers read 0, and `irq_o` and `rst_req_o` are low.
- R2: The counter changes only while the run bit (control bit 0) is set. While it runs, the value drops by one per clock. On the clock after the value reaches 0, the counter takes the reload value and signals a time-out, which gives a period of reload+1 clocks.
- R3: A time-out while the raw status is clear sets the raw status (address 4, bit 0). `irq_o` and the masked status (address 5, bit 0) equal the raw status ANDed with the interrupt-enable bit (control bit 1).
- R4: A time-out while the raw status is already set asserts `rst_req_o` only when the reset-enable bit (control bit 2) is set. With that bit clear, the time-out leaves `rst_req_o` low.
- R5: Once asserted, `rst_req_o` stays high until the block is reset, whatever software writes.
- R6: A write of any value to the clear register (address 3) clears the raw status and reloads the counter from the reload register on the same clock edge. Lock state does not affect this.
- R7: A write to the reload register (address 0) updates it and loads the counter with the written value on the same edge.
- R8: Writing 0x1ACCE551 to the lock register (address 6) unlocks it, and writing any other value locks it. The register reads 1 when locked and 0 when unlocked. While it is locked, writes to the reload and control registers have no effect.
- R9: While the stall bit (control bit 3) and `halt_i` are both high, the counter holds its value and no time-out occurs.
- R10: Once set, the run bit cannot be cleared by software. Only reset clears it.
- R11: Address map: 0 reload, 1 current value (read only), 2 control, 3 clear (write only), 4 raw status, 5 masked status, 6 lock. All other addresses, and the clear register, read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| halt_i | input | 1 | Debug halt indication |
| irq_o | output | 1 | Masked time-out interrupt |
| rst_req_o | output | 1 | Sticky system reset request |

## Verification
Assertions in the RTL check on every clock that reset requests are sticky, that the run bit never falls, that a locked reload register stays stable, that the counter decrements, reloads and holds during a stall exactly as required, and that a first time-out sets the raw status. Only the bench's scenarios show the escalation as seen at the ports: the interrupt on the first expiry at exactly reload+1 clocks, no reset when reset generation is disabled, a reset on the second expiry when it is enabled, the masking of the interrupt, and the register map seen through reads.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned CTRL_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_LOAD   = 3'd0,
    REG_VALUE  = 3'd1,
    REG_CTRL   = 3'd2,
    REG_CLEAR  = 3'd3,
    REG_RAW    = 3'd4,
    REG_MASKED = 3'd5,
    REG_LOCK   = 3'd6
  } reg_addr_e;

  localparam int unsigned CB_RUN   = 0;
  localparam int unsigned CB_IEN   = 1;
  localparam int unsigned CB_REN   = 2;
  localparam int unsigned CB_STALL = 3;
endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             hold_i,
  input  logic             force_reload_i,
  input  logic [CNT_W-1:0] reload_val_i,
  input  logic [CNT_W-1:0] period_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             timeout_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tick, at_zero;

  assign tick    = run_i && !hold_i;
  assign at_zero = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (force_reload_i)  cnt_d = reload_val_i;
    else if (tick)       cnt_d = at_zero ? period_val_i : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '1;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o     = cnt_q;
  assign timeout_o = tick && at_zero && !force_reload_i;

  p_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !force_reload_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !force_reload_i) |=> $stable(cnt_q));
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && !force_reload_i) |=> $stable(cnt_q));
  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    force_reload_i |=> (cnt_q == $past(reload_val_i)));
endmodule

// File: rtl/wdog_lock.sv
module wdog_lock #(
  parameter int unsigned        DATA_W = 32,
  parameter logic [DATA_W-1:0]  KEY    = 32'h1ACC_E551
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              locked_o
);
  logic lock_q, lock_d;

  always_comb begin
    lock_d = lock_q;
    if (wr_i) lock_d = (wdata_i != KEY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b0;
    else        lock_q <= lock_d;
  end

  assign locked_o = lock_q;

  p_key_opens_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && wdata_i == KEY) |=> !locked_o);
  p_other_closes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && wdata_i != KEY) |=> locked_o);
endmodule

// File: rtl/wdog_escalate.sv
module wdog_escalate (
  input  logic clk,
  input  logic rst_n,
  input  logic timeout_i,
  input  logic clear_i,
  input  logic irq_en_i,
  input  logic rst_en_i,
  output logic raw_o,
  output logic irq_o,
  output logic rst_req_o
);
  logic raw_q, raw_d, rreq_q, rreq_d;

  always_comb begin
    raw_d = raw_q;
    if (clear_i)        raw_d = 1'b0;
    else if (timeout_i) raw_d = 1'b1;
    rreq_d = rreq_q | (timeout_i && raw_q && rst_en_i && !clear_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= 1'b0;
      rreq_q <= 1'b0;
    end else begin
      raw_q  <= raw_d;
      rreq_q <= rreq_d;
    end
  end

  assign raw_o     = raw_q;
  assign irq_o     = raw_q & irq_en_i;
  assign rst_req_o = rreq_q;

  p_first_timeout_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_i && !clear_i) |=> raw_q);
  p_rst_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rreq_q |=> rreq_q);
  p_no_rst_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rreq_q && !rst_en_i) |=> !rreq_q);
  p_rst_needs_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rreq_q) |-> $past(raw_q));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int unsigned       CNT_W    = 32,
  parameter int unsigned       SYNC_LEN = 2,
  parameter logic [CNT_W-1:0]  KEY      = 32'h1ACC_E551
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  input  logic              halt_i,
  output logic              irq_o,
  output logic              rst_req_o
);
  logic              srst_n;
  logic [CNT_W-1:0]  load_q, load_d, cnt;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              locked, raw, timeout, hold;
  logic              wr_load, wr_ctrl, wr_clear, wr_lock, cfg_ok;

  wdog_rst_sync #(.STAGES(SYNC_LEN)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(srst_n)
  );

  assign cfg_ok   = !locked;
  assign wr_load  = we_i && (addr_i == REG_LOAD) && cfg_ok;
  assign wr_ctrl  = we_i && (addr_i == REG_CTRL) && cfg_ok;
  assign wr_clear = we_i && (addr_i == REG_CLEAR);
  assign wr_lock  = we_i && (addr_i == REG_LOCK);

  always_comb begin
    load_d = load_q;
    ctrl_d = ctrl_q;
    if (wr_load) load_d = wdata_i;
    if (wr_ctrl) begin
      ctrl_d = wdata_i[CTRL_W-1:0];
      ctrl_d[CB_RUN] = ctrl_q[CB_RUN] | wdata_i[CB_RUN];
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      load_q <= '1;
      ctrl_q <= '0;
    end else begin
      load_q <= load_d;
      ctrl_q <= ctrl_d;
    end
  end

  assign hold = ctrl_q[CB_STALL] && halt_i;

  wdog_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(srst_n),
    .run_i(ctrl_q[CB_RUN]), .hold_i(hold),
    .force_reload_i(wr_load || wr_clear),
    .reload_val_i(wr_load ? wdata_i : load_q),
    .period_val_i(load_q),
    .cnt_o(cnt), .timeout_o(timeout)
  );

  wdog_lock #(.DATA_W(CNT_W), .KEY(KEY)) u_lock (
    .clk(clk), .rst_n(srst_n), .wr_i(wr_lock),
    .wdata_i(wdata_i), .locked_o(locked)
  );

  wdog_escalate u_escalate (
    .clk(clk), .rst_n(srst_n), .timeout_i(timeout), .clear_i(wr_clear),
    .irq_en_i(ctrl_q[CB_IEN]), .rst_en_i(ctrl_q[CB_REN]),
    .raw_o(raw), .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_LOAD:   rdata_o = load_q;
      REG_VALUE:  rdata_o = cnt;
      REG_CTRL:   rdata_o[CTRL_W-1:0] = ctrl_q;
      REG_RAW:    rdata_o[0] = raw;
      REG_MASKED: rdata_o[0] = irq_o;
      REG_LOCK:   rdata_o[0] = locked;
      default:    rdata_o = '0;
    endcase
  end

  p_locked_load_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (locked && we_i && addr_i == REG_LOAD) |=> $stable(load_q));
  p_locked_ctrl_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (locked && we_i && addr_i == REG_CTRL) |=> $stable(ctrl_q));
  p_run_sticky_r10: assert property (@(posedge clk) disable iff (!srst_n)
    ctrl_q[CB_RUN] |=> ctrl_q[CB_RUN]);
endmodule

// File: tb/wdog_timer_bench.sv
module wdog_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KEY = 32'h1ACC_E551;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        we;
  logic [2:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        halt;
  logic        irq, rreq;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_timer u_wdog_timer (
    .clk(clk), .rst_n(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .halt_i(halt), .irq_o(irq), .rst_req_o(rreq)
  );

  typedef struct packed {
    logic        wr;
    logic [2:0]  adr;
    logic [31:0] dat;
  } op_t;

  localparam int NOPS = 19;
  localparam op_t OPS [NOPS] = '{
    '{1'b0, 3'd0, 32'hFFFF_FFFF},
    '{1'b0, 3'd1, 32'hFFFF_FFFF},
    '{1'b0, 3'd2, 32'h0},
    '{1'b0, 3'd4, 32'h0},
    '{1'b0, 3'd6, 32'h0},
    '{1'b0, 3'd7, 32'h0},
    '{1'b1, 3'd0, 32'h0000_1234},
    '{1'b0, 3'd1, 32'h0000_1234},
    '{1'b0, 3'd0, 32'h0000_1234},
    '{1'b1, 3'd6, 32'h0},
    '{1'b0, 3'd6, 32'h1},
    '{1'b1, 3'd0, 32'h0000_0055},
    '{1'b0, 3'd0, 32'h0000_1234},
    '{1'b1, 3'd2, 32'hE},
    '{1'b0, 3'd2, 32'h0},
    '{1'b1, 3'd6, KEY},
    '{1'b0, 3'd6, 32'h0},
    '{1'b1, 3'd2, 32'h2},
    '{1'b0, 3'd2, 32'h2}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0; halt = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, r;
    do_reset();

    // Table walk: reset state (R1), reload write (R7), lock (R8), map (R11)
    for (int i = 0; i < NOPS; i++) begin
      @(negedge clk);
      we = OPS[i].wr; addr = OPS[i].adr; wdata = OPS[i].dat;
      if (!OPS[i].wr) begin
        #1;
        chk($sformatf("table step %0d (R1/R7/R8/R11)", i), rdata, OPS[i].dat);
      end
      @(posedge clk);
    end
    @(negedge clk);
    we = 1'b0;

    // R1: outputs after reset
    do_reset();
    chk("R1 irq_o after reset", {31'b0, irq}, 32'h0);
    chk("R1 rst_req_o after reset", {31'b0, rreq}, 32'h0);

    // R7 / R2: reload write loads counter; idle without run
    wr(3'd0, 32'd5);
    rd(3'd1, r); chk("R7 value after reload write", r, 32'd5);
    repeat (3) @(posedge clk); @(negedge clk);
    rd(3'd1, r); chk("R2 counter idle without run", r, 32'd5);

    // R2 / R3: first expiry after reload+1 clocks
    wr(3'd2, 32'h3);
    repeat (5) @(posedge clk); @(negedge clk);
    rd(3'd1, r); chk("R2 value reaches zero", r, 32'd0);
    chk("R3 no irq before expiry", {31'b0, irq}, 32'h0);
    @(posedge clk); @(negedge clk);
    chk("R3 irq on first expiry", {31'b0, irq}, 32'h1);
    rd(3'd1, r); chk("R2 wrap reloads", r, 32'd5);
    rd(3'd4, r); chk("R3 raw status set", r, 32'h1);
    rd(3'd5, r); chk("R3 masked status set", r, 32'h1);

    // R4: second expiry with reset generation off
    repeat (6) @(posedge clk); @(negedge clk);
    chk("R4 no reset when disabled", {31'b0, rreq}, 32'h0);

    // R10: run cannot be cleared
    wr(3'd2, 32'h2);
    rd(3'd2, r); chk("R10 run bit sticky", r, 32'h3);

    // R3: masking
    wr(3'd2, 32'h1);
    chk("R3 irq masked", {31'b0, irq}, 32'h0);
    rd(3'd5, r); chk("R3 masked status off", r, 32'h0);
    rd(3'd4, r); chk("R3 raw still set", r, 32'h1);

    // R6: clear
    wr(3'd3, 32'hDEAD_BEEF);
    rd(3'd4, r); chk("R6 raw cleared", r, 32'h0);
    rd(3'd1, r); chk("R6 counter reloaded", r, 32'd5);

    // R9: debug stall
    wr(3'd0, 32'd100);
    wr(3'd2, 32'h9);
    halt = 1'b1;
    rd(3'd1, v);
    repeat (10) @(posedge clk); @(negedge clk);
    rd(3'd1, r); chk("R9 counter frozen in halt", r, v);
    halt = 1'b0;
    @(posedge clk); @(negedge clk);
    rd(3'd1, r); chk("R9 counter resumes", r, v - 32'd1);

    // R4 / R5: escalation to reset, sticky
    wr(3'd0, 32'd3);
    wr(3'd2, 32'h5);
    repeat (20) @(posedge clk); @(negedge clk);
    chk("R4 reset on second expiry", {31'b0, rreq}, 32'h1);
    wr(3'd3, 32'h0);
    rd(3'd4, r); chk("R6 clear while reset pending", r, 32'h0);
    repeat (10) @(posedge clk); @(negedge clk);
    chk("R5 reset request sticky", {31'b0, rreq}, 32'h1);
    do_reset();
    chk("R5 reset clears request", {31'b0, rreq}, 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule